// File: doc/BRIEF.md
# Nibble-Packed Sample Player

This block streams 4-bit audio samples out of byte-wide memory, where each byte holds two samples. A small write-only register file sets where playback starts and stops and where a loop starts. It also sets how many times the loop repeats, how fast the player advances and which half of each byte plays first. Writing a nonzero value to the trigger register arms a restart. The restart takes effect on the next output-sample tick.

On every tick, the rate logic adds the quotient of the system clock frequency and a programmed 16-bit cycle period to an accumulator. When that total reaches the output sample rate, the player takes one nibble. Each nibble becomes a signed 16-bit level that the output holds until the next step. When the player reaches the end address, it either jumps back to the loop address, while repeats remain, or goes idle. The output is meant to feed a mixer elsewhere in the chip.

Top module: `nibble_player`

## Requirements
- R1: Out of reset, `sample_out` is 0 and `mem_rd_en` is low.
- R2: A nonzero write to the trigger register (index 0) arms a restart, which is consumed by the next tick. The restart enables playback only if the written value is 0xFE or above. A later tick without a new write does not restart again.
- R3: On restart, the rate accumulator and the nibble phase clear. The current address loads from the start pair (index 1 = low byte, index 2 = high byte). The repeat counter loads from index 7.
- R4: On each tick while enabled, if the period (index 8 = low byte, index 9 = high byte) is nonzero, floor(CPU_HZ/period) is added to the accumulator. When the accumulator is at or above SAMPLE_HZ, SAMPLE_HZ is subtracted and one step occurs. A zero period never steps.
- R5: A step issues a one-cycle read with `mem_rd_en` high in the cycle after the tick. The read goes to the current address, and only if that address is below the end pair (index 3 = low byte, index 4 = high byte).
- R6: A step at or past the end address with a nonzero repeat count issues no read. Instead, it loads the loop address and decrements the count. The loop pair is stored high byte first: index 5 = high byte, index 6 = low byte.
- R7: With the order register (index 10) at zero, the high nibble of a byte plays first; with it nonzero, the low nibble plays first. The address advances by one only after the second nibble of a byte.
- R8: The output becomes (nibble − 8) × AMP, with AMP = 1200. It changes in the third cycle after the tick, and it is unchanged in the second cycle.
- R9: While playback is disabled, or after the end is reached with no repeats left, no reads are issued and `sample_out` holds its last value.
- R10: Ticks spaced three cycles apart each complete their output update before the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 4 | Register index |
| wr_data | input | 8 | Register write data |
| tick | input | 1 | Output-sample tick, one cycle wide |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory byte address |
| mem_rd_data | input | 8 | Read data, valid the cycle after `mem_rd_en` |
| sample_out | output | 16 | Signed sample level |

## Verification
The bench builds the block with CPU_HZ = 1000, SAMPLE_HZ = 100 and a 24-bit accumulator. With these values, a period of 10 steps on every tick, a period of 20 steps on every second tick, and a period of 0 never steps. Each of these cadences shows up within a few ticks. A 256-byte model memory, indexed by the low address byte, lets the bench place loop and end addresses across a high-byte boundary. That placement shows the reversed byte order of the loop pair. The table walks several byte values under both nibble orders. Directed cases then cover restarts in the middle of a byte, stale accumulator contents, triggers that do not enable playback, and the end of playback.

// File: rtl/nsp_pkg.sv
package nsp_pkg;
    localparam int ADDR_W = 16;
    localparam int IDX_W  = 4;

    localparam logic [IDX_W-1:0] RI_TRIG     = 4'd0;
    localparam logic [IDX_W-1:0] RI_START_LO = 4'd1;
    localparam logic [IDX_W-1:0] RI_START_HI = 4'd2;
    localparam logic [IDX_W-1:0] RI_END_LO   = 4'd3;
    localparam logic [IDX_W-1:0] RI_END_HI   = 4'd4;
    localparam logic [IDX_W-1:0] RI_LOOP_HI  = 4'd5;
    localparam logic [IDX_W-1:0] RI_LOOP_LO  = 4'd6;
    localparam logic [IDX_W-1:0] RI_REPEAT   = 4'd7;
    localparam logic [IDX_W-1:0] RI_PER_LO   = 4'd8;
    localparam logic [IDX_W-1:0] RI_PER_HI   = 4'd9;
    localparam logic [IDX_W-1:0] RI_ORDER    = 4'd10;

    localparam logic [7:0] ENABLE_MIN = 8'hFE;

    typedef struct packed {
        logic [7:0]        trig;
        logic [ADDR_W-1:0] start;
        logic [ADDR_W-1:0] stop;
        logic [ADDR_W-1:0] loop;
        logic [7:0]        repeats;
        logic [15:0]       period;
        logic              low_first;
    } cfg_t;
endpackage

// File: rtl/nsp_regfile.sv
module nsp_regfile
    import nsp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic             tick,
    output cfg_t             cfg
);
    cfg_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        // a tick consumes the trigger; a write in the same cycle wins
        if (tick) c_d.trig = '0;
        if (wr_en) begin
            case (wr_idx)
                RI_TRIG:     c_d.trig         = wr_data;
                RI_START_LO: c_d.start[7:0]   = wr_data;
                RI_START_HI: c_d.start[15:8]  = wr_data;
                RI_END_LO:   c_d.stop[7:0]    = wr_data;
                RI_END_HI:   c_d.stop[15:8]   = wr_data;
                RI_LOOP_HI:  c_d.loop[15:8]   = wr_data;
                RI_LOOP_LO:  c_d.loop[7:0]    = wr_data;
                RI_REPEAT:   c_d.repeats      = wr_data;
                RI_PER_LO:   c_d.period[7:0]  = wr_data;
                RI_PER_HI:   c_d.period[15:8] = wr_data;
                RI_ORDER:    c_d.low_first    = |wr_data;
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cfg = c_q;
endmodule

// File: rtl/nsp_rate.sv
module nsp_rate #(
    parameter int CPU_HZ    = 985248,
    parameter int SAMPLE_HZ = 44100,
    parameter int ACC_W     = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        restart,
    input  logic        run,
    input  logic [15:0] period,
    output logic        step
);
    localparam logic [ACC_W-1:0] CPU_V = ACC_W'(CPU_HZ);
    localparam logic [ACC_W-1:0] SR_V  = ACC_W'(SAMPLE_HZ);

    logic [ACC_W-1:0] acc_d, acc_q;
    logic [ACC_W-1:0] inc, base, sum;

    always_comb begin
        inc   = (period == '0) ? '0 : CPU_V / ACC_W'(period);
        base  = restart ? '0 : acc_q;
        sum   = base + inc;
        acc_d = base;
        step  = 1'b0;
        if (tick && run) begin
            if (sum >= SR_V) begin
                acc_d = sum - SR_V;
                step  = 1'b1;
            end else begin
                acc_d = sum;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end
endmodule

// File: rtl/nsp_fetch.sv
module nsp_fetch
    import nsp_pkg::*;
#(
    parameter int AMP = 1200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              step,
    input  cfg_t              cfg,
    input  logic [7:0]        mem_rd_data,
    output logic              en,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       level
);
    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic              phase;
        logic [7:0]        reps;
        logic              rd;
        logic [ADDR_W-1:0] raddr;
        logic              rhi;
        logic              cap;
        logic              chi;
        logic [15:0]       out;
    } st_t;

    st_t s_d, s_q;
    logic [3:0]         nib;
    logic signed [31:0] prod;

    always_comb begin
        s_d     = s_q;
        s_d.rd  = 1'b0;
        s_d.cap = s_q.rd;
        s_d.chi = s_q.rhi;
        nib     = s_q.chi ? mem_rd_data[7:4] : mem_rd_data[3:0];
        prod    = (signed'({28'd0, nib}) - 32'sd8) * 32'(AMP);

        if (restart) begin
            s_d.en    = (cfg.trig >= ENABLE_MIN);
            s_d.addr  = cfg.start;
            s_d.phase = 1'b0;
            s_d.reps  = cfg.repeats;
        end

        if (step) begin
            if (s_d.addr < cfg.stop) begin
                s_d.rd    = 1'b1;
                s_d.raddr = s_d.addr;
                s_d.rhi   = s_d.phase ? cfg.low_first : !cfg.low_first;
                if (s_d.phase) s_d.addr = s_d.addr + 1'b1;
                s_d.phase = !s_d.phase;
            end else if (s_d.reps != '0) begin
                s_d.addr = cfg.loop;
                s_d.reps = s_d.reps - 1'b1;
            end
        end

        if (s_q.cap) s_d.out = prod[15:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign en        = s_q.en;
    assign mem_rd_en = s_q.rd;
    assign mem_addr  = s_q.raddr;
    assign level     = s_q.out;
endmodule

// File: rtl/nibble_player.sv
module nibble_player
    import nsp_pkg::*;
#(
    parameter int CPU_HZ    = 985248,
    parameter int SAMPLE_HZ = 44100,
    parameter int AMP       = 1200,
    parameter int ACC_W     = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [3:0]         wr_idx,
    input  logic [7:0]         wr_data,
    input  logic               tick,
    output logic               mem_rd_en,
    output logic [15:0]        mem_addr,
    input  logic [7:0]         mem_rd_data,
    output logic signed [15:0] sample_out
);
    cfg_t        cfg;
    logic        restart, run, step, en;
    logic [15:0] level;

    nsp_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .tick(tick), .cfg(cfg)
    );

    always_comb begin
        restart = tick && (cfg.trig != '0);
        run     = restart ? (cfg.trig >= ENABLE_MIN) : en;
    end

    nsp_rate #(.CPU_HZ(CPU_HZ), .SAMPLE_HZ(SAMPLE_HZ), .ACC_W(ACC_W)) u_rate (
        .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart),
        .run(run), .period(cfg.period), .step(step)
    );

    nsp_fetch #(.AMP(AMP)) u_fetch (
        .clk(clk), .rst_n(rst_n), .restart(restart), .step(step), .cfg(cfg),
        .mem_rd_data(mem_rd_data), .en(en), .mem_rd_en(mem_rd_en),
        .mem_addr(mem_addr), .level(level)
    );

    assign sample_out = signed'(level);
endmodule

// File: rtl/nsp_checks.sv
module nsp_checks #(
    parameter int AMP = 1200
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick,
    input logic               mem_rd_en,
    input logic signed [15:0] sample_out
);
    // R10: ticks at least three cycles apart
    a_r10_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (!$past(tick) && !$past(tick, 2)));

    // R5: a read only follows a tick
    a_r5_read_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> $past(tick));

    // R5: reads are single-cycle pulses
    a_r5_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    // R8: output changes only two cycles after a read
    a_r8_out_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sample_out) |-> $past(mem_rd_en, 2));

    // R8: output stays within the scaled nibble range
    a_r8_out_range: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(sample_out) >= -8 * AMP) && (32'(sample_out) <= 7 * AMP));
endmodule

bind nibble_player nsp_checks #(.AMP(AMP)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .mem_rd_en(mem_rd_en), .sample_out(sample_out)
);

// File: tb/nibble_player_test.sv
`timescale 1ns/1ps
module nibble_player_test;
    localparam int CPU_HZ = 1000, SAMPLE_HZ = 100, AMP = 1200, ACC_W = 24;
    localparam int NV = 6;
    localparam logic [7:0] V_BYTE [NV] = '{8'h3C, 8'h3C, 8'h08, 8'hF7, 8'h80, 8'hA5};
    localparam logic [7:0] V_LOW  [NV] = '{8'd0, 8'd1, 8'd0, 8'd1, 8'd0, 8'd1};
    localparam int         V_E1   [NV] = '{-6000, 4800, -9600, -1200, 0, -3600};
    localparam int         V_E2   [NV] = '{4800, -6000, 0, 8400, -9600, 2400};

    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, tick = 1'b0;
    logic [3:0] wr_idx = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] mem_rd_data;
    logic mem_rd_en;
    logic [15:0] mem_addr;
    logic signed [15:0] sample_out;
    logic [7:0] mem [256];

    int total = 0, bad = 0;
    bit done = 1'b0;
    bit rd_seen;
    int rd_addr, mid_out, prev_out;

    always #10 clk = ~clk;

    always_ff @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_addr[7:0]];

    nibble_player #(.CPU_HZ(CPU_HZ), .SAMPLE_HZ(SAMPLE_HZ), .AMP(AMP), .ACC_W(ACC_W)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .tick(tick), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rd_data(mem_rd_data), .sample_out(sample_out)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'(idx); wr_data = 8'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // tick, capture read at +1, output at +2 and +3 cycles
    task automatic tk();
        @(negedge clk);
        prev_out = int'(sample_out);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        rd_seen = mem_rd_en;
        rd_addr = int'(mem_addr);
        @(negedge clk);
        mid_out = int'(sample_out);
        @(negedge clk);
    endtask

    task automatic setup(input int start, input int stop, input int per, input int order);
        wr(1, start & 255); wr(2, start >> 8);
        wr(3, stop & 255);  wr(4, stop >> 8);
        wr(8, per & 255);   wr(9, per >> 8);
        wr(10, order);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h88;
        repeat (3) @(negedge clk);
        check("R1 out", int'(sample_out), 0);
        check("R1 rd_en", int'(mem_rd_en), 0);
        rst_n = 1'b1;

        // table walk: nibble order and scaling (R7, R8, R10)
        for (int i = 0; i < NV; i++) begin
            mem[8'h10] = V_BYTE[i];
            setup(16'h0010, 16'h0011, 10, int'(V_LOW[i]));
            wr(0, 8'hFF);
            tk();
            check("R5 read issued", int'(rd_seen), 1);
            check("R5 read addr", rd_addr, 16'h0010);
            check("R8 held one cycle", mid_out, prev_out);
            check("R7 first nibble", int'(sample_out), V_E1[i]);
            tk();
            check("R7 second nibble same addr", rd_addr, 16'h0010);
            check("R10 back-to-back second", int'(sample_out), V_E2[i]);
            tk();
            check("R9 no read at end", int'(rd_seen), 0);
            check("R9 out held at end", int'(sample_out), V_E2[i]);
        end

        // R2: trigger below 0xFE does not enable
        mem[8'h10] = 8'h00;
        wr(0, 8'h80);
        tk();
        check("R2 low trigger no read", int'(rd_seen), 0);
        check("R2 low trigger out held", int'(sample_out), 2400);
        wr(0, 8'hFE);
        tk();
        check("R2 FE enables", int'(rd_seen), 1);
        check("R2 FE out", int'(sample_out), -9600);

        // R2: trigger consumed, stepping continues across bytes
        mem[8'h20] = 8'h12; mem[8'h21] = 8'h34;
        setup(16'h0020, 16'h0024, 10, 0);
        wr(0, 8'hFF);
        tk(); check("R7 hi first", int'(sample_out), -8400);
        tk(); check("R7 lo second", int'(sample_out), -7200);
        tk();
        check("R2 no re-restart addr", rd_addr, 16'h0021);
        check("R7 next byte", int'(sample_out), -6000);

        // R3: restart mid-byte clears phase
        wr(0, 8'hFF);
        tk();
        check("R3 addr reload", rd_addr, 16'h0020);
        check("R3 phase cleared", int'(sample_out), -8400);

        // R4: period 20 steps every second tick
        setup(16'h0020, 16'h0024, 20, 0);
        wr(0, 8'hFF);
        tk(); check("R4 p20 tick1", int'(rd_seen), 0);
        tk(); check("R4 p20 tick2", int'(rd_seen), 1);
        tk(); check("R4 p20 tick3", int'(rd_seen), 0);
        tk(); check("R4 p20 tick4", int'(rd_seen), 1);
        // R3: accumulator cleared by restart
        tk(); // acc now half way
        wr(0, 8'hFF);
        tk(); check("R3 acc cleared", int'(rd_seen), 0);

        // R4: zero period never steps
        setup(16'h0020, 16'h0024, 0, 0);
        wr(0, 8'hFF);
        tk(); check("R4 p0 tick1", int'(rd_seen), 0);
        tk(); check("R4 p0 tick2", int'(rd_seen), 0);

        // R6: loop with repeat, loop pair high byte first
        mem[8'hFF] = 8'h9B; mem[8'hFE] = 8'h6D;
        setup(16'h01FF, 16'h0200, 10, 0);
        wr(5, 8'h01); wr(6, 8'hFE); wr(7, 1);
        wr(0, 8'hFF);
        tk(); check("R6 first addr", rd_addr, 16'h01FF);
        check("R8 first level", int'(sample_out), 1200);
        tk(); check("R8 second level", int'(sample_out), 3600);
        tk();
        check("R6 reload no read", int'(rd_seen), 0);
        check("R6 reload out held", int'(sample_out), 3600);
        tk();
        check("R6 loop addr", rd_addr, 16'h01FE);
        check("R6 loop level", int'(sample_out), -2400);
        tk(); check("R6 loop second", int'(sample_out), 6000);
        tk(); check("R6 walk on", rd_addr, 16'h01FF);
        tk();
        tk(); check("R9 repeats spent", int'(rd_seen), 0);
        tk();
        check("R9 stays idle", int'(rd_seen), 0);
        check("R9 final out held", int'(sample_out), 3600);

        // R9: disable mid-play
        wr(0, 8'hFF);
        tk(); check("R9 replay read", int'(rd_seen), 1);
        wr(0, 8'h01);
        tk();
        check("R9 disabled no read", int'(rd_seen), 0);
        check("R9 disabled out held", int'(sample_out), 1200);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule